// File: doc/BRIEF.md
# PWM Timer with Event Action Outputs

This block is one PWM channel pair. A 16-bit time-base counter advances once per prescaled tick and counts up from 0 to a programmable period, then starts again at 0. The tick comes from a two-stage prescaler. The first stage divides by a power of two. The second stage divides by 1 or by an even number up to 14. The two ratios multiply.

There are two outputs, A and B. Neither is a plain comparison against the counter. Each output is a register that is set, cleared or toggled by two events: the counter arriving at zero, and the counter arriving at that output's own compare value while counting up.

Software drives the block through a one-cycle write strobe, a 3-bit address and 16 bits of data. The write port programs these fields:
- the control word;
- the period;
- the two compare values;
- the action codes;
- the counter itself.

The counter value is brought out so that the time base can be observed.

Top module: `pwm_aq_timer`

## Requirements
- R1: After reset, `pwm_a` and `pwm_b` are low and `tb_count` is 0. Every register is 0, including the time-base enable, so the counter does not move until it is enabled.
- R2: The tick ratio is R = C x F. C is 2 to the power of the coarse code in control bits [2:0]. F is 1 when the fine code in control bits [5:3] is 0, and twice the code otherwise. The counter advances once every R clock cycles.
- R3: In up-count mode (control bit 6 clear), the counter steps 0, 1, ..., P and then returns to 0. P is the active period, written at address 1. One full period lasts R x (P + 1) clock cycles.
- R4: The action register at address 4 holds four 2-bit codes: [1:0] output A on zero, [3:2] output A on compare A, [5:4] output B on zero, [7:6] output B on compare B. Code 0 is none, 1 is clear, 2 is set and 3 is toggle. Compare A is written at address 2 and compare B at address 3. With set-on-zero and clear-on-compare and a compare value K with 1 <= K <= P, an output is high for R x K cycles of every period.
- R5: Code 3 inverts the output on each event it is attached to. Code 0 leaves the output unchanged.
- R6: When a compare value is 0, the zero event and the compare event fall on the same tick. The compare action then wins.
- R7: With control bit 6 set (freeze), the counter and both outputs hold their values.
- R8: With control bit 8 (time-base enable) clear, the counter holds its value.
- R9: A write to address 5 loads the counter with the written value on the following clock edge.
- R10: With control bit 7 clear, a period write takes effect at once. A counter that is above the new period wraps to 0 on the next tick.
- R11: With control bit 7 set, a period write is held back. It moves to the active period at the next counter-zero event, so the current period completes with its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address: 0 control, 1 period, 2 compare A, 3 compare B, 4 actions, 5 counter |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | Output A, registered |
| pwm_b | output | 1 | Output B, registered |
| tb_count | output | 16 | Current time-base counter value |

## Verification
A write changes its register at the clock edge that ends the strobe cycle. A counter write therefore shows on `tb_count` one edge after the strobe. A control write that raises the enable produces its first tick at the next edge: one register for the enable, one for the prescaler count. The counter and the outputs change at that same edge, because event detection uses the counter's next value and the outputs are updated together with the counter.

The bench drives all inputs at falling edges and samples at falling edges, so every sample falls between these edges. Duty and period checks do not assume a fixed start cycle. Each one waits for a rising edge on output A and then counts over a window of exactly two periods. Sequence checks on the counter look at the range of values it visits, not at one fixed cycle.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  localparam int CODE_W  = 3;
  localparam int MAX_DIV = (1 << ((1 << CODE_W) - 1)) * 2 * ((1 << CODE_W) - 1);
  localparam int PS_W    = $clog2(MAX_DIV + 1);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PRD  = 3'd1;
  localparam logic [2:0] A_CMPA = 3'd2;
  localparam logic [2:0] A_CMPB = 3'd3;
  localparam logic [2:0] A_ACT  = 3'd4;
  localparam logic [2:0] A_CNT  = 3'd5;

  // Ratio of both prescaler stages: power of two times (1 or 2*code).
  function automatic int unsigned div_ratio(input logic [CODE_W-1:0] coarse,
                                            input logic [CODE_W-1:0] fine);
    int unsigned f;
    f = (fine == '0) ? 1 : 2 * int'(fine);
    return (32'd1 << coarse) * f;
  endfunction

  // New level of an output after an action.
  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_CLR: return 1'b0;
      ACT_SET: return 1'b1;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  logic [W-1:0] pcnt;
  logic         last;

  assign last = (pcnt >= ratio - W'(1));
  assign tick = en && !clr && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (clr)     pcnt <= '0;
    else if (en)      pcnt <= last ? '0 : pcnt + W'(1);
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         ld_cnt,
  input  logic         prd_wr,
  input  logic         shadow_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         zero_evt
);
  logic [W-1:0] prd_act, prd_shd;
  logic         pend;

  assign nxt      = (cnt >= prd_act) ? '0 : cnt + W'(1);
  assign zero_evt = adv && (nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (ld_cnt) cnt <= wdata;
    else if (adv)    cnt <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_act <= '0;
      prd_shd <= '0;
      pend    <= 1'b0;
    end else begin
      if (zero_evt && pend) begin
        prd_act <= prd_shd;
        pend    <= 1'b0;
      end
      if (prd_wr && !shadow_en) prd_act <= wdata;
      if (prd_wr && shadow_en) begin
        prd_shd <= wdata;
        pend    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_action.sv
module pwm_action
  import pwm_aq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt,
  input  logic cmp_evt,
  input  act_e zero_act,
  input  act_e cmp_act,
  output logic out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out <= 1'b0;
    else if (cmp_evt)  out <= apply_act(cmp_act, out);
    else if (zero_evt) out <= apply_act(zero_act, out);
  end
endmodule

// File: rtl/pwm_aq_timer.sv
module pwm_aq_timer
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic [CNT_W-1:0]  tb_count
);
  localparam int NOUT = 2;

  logic [CODE_W-1:0] coarse_q, fine_q;
  logic              freeze_q, shadow_q, tb_en_q;
  logic [CNT_W-1:0]  cmp_q [NOUT];
  act_e              zact_q [NOUT];
  act_e              cact_q [NOUT];

  logic              ctrl_wr, prd_wr, cnt_wr;
  logic              tick, adv, zero_evt;
  logic [CNT_W-1:0]  cnt, nxt;
  logic [NOUT-1:0]   cmp_evt, outs;
  logic [PS_W-1:0]   ratio;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign prd_wr  = wr_en && (wr_addr == ADDR_W'(A_PRD));
  assign cnt_wr  = wr_en && (wr_addr == ADDR_W'(A_CNT));
  assign ratio   = PS_W'(div_ratio(coarse_q, fine_q));
  assign adv     = tick && !freeze_q && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      fine_q   <= '0;
      freeze_q <= 1'b0;
      shadow_q <= 1'b0;
      tb_en_q  <= 1'b0;
      for (int i = 0; i < NOUT; i++) begin
        cmp_q[i]  <= '0;
        zact_q[i] <= ACT_NONE;
        cact_q[i] <= ACT_NONE;
      end
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_CTRL): begin
          coarse_q <= wr_data[CODE_W-1:0];
          fine_q   <= wr_data[2*CODE_W-1:CODE_W];
          freeze_q <= wr_data[6];
          shadow_q <= wr_data[7];
          tb_en_q  <= wr_data[8];
        end
        ADDR_W'(A_CMPA): cmp_q[0] <= wr_data;
        ADDR_W'(A_CMPB): cmp_q[1] <= wr_data;
        ADDR_W'(A_ACT): begin
          for (int i = 0; i < NOUT; i++) begin
            zact_q[i] <= act_e'(wr_data[4*i +: 2]);
            cact_q[i] <= act_e'(wr_data[4*i+2 +: 2]);
          end
        end
        default: ;
      endcase
    end
  end

  pwm_prescaler #(.W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_wr), .en(tb_en_q),
    .ratio(ratio), .tick(tick)
  );

  pwm_timebase #(.W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ld_cnt(cnt_wr), .prd_wr(prd_wr),
    .shadow_en(shadow_q), .wdata(wr_data), .cnt(cnt), .nxt(nxt),
    .zero_evt(zero_evt)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    assign cmp_evt[g] = adv && (nxt == cmp_q[g]);
    pwm_action u_act (
      .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .cmp_evt(cmp_evt[g]),
      .zero_act(zact_q[g]), .cmp_act(cact_q[g]), .out(outs[g])
    );
  end

  assign pwm_a    = outs[0];
  assign pwm_b    = outs[1];
  assign tb_count = cnt;
endmodule

// File: rtl/pwm_aq_checker.sv
module pwm_aq_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv,
  input logic             zero_evt,
  input logic [1:0]       cmp_evt,
  input logic             tb_en,
  input logic             freeze,
  input logic             cnt_wr,
  input logic [1:0]       cmp_act_a,
  input logic [CNT_W-1:0] cnt,
  input logic             pwm_a
);
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_en && !cnt_wr) |=> $stable(cnt)); // R8

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_wr) |=> $stable(cnt)); // R7

  AST_ZERO_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (cnt == '0)); // R3

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_evt && !cmp_evt[0]) |=> $stable(pwm_a)); // R5

  AST_CMP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt[0] && zero_evt && cmp_act_a == 2'd1) |=> !pwm_a); // R6

  AST_EVT_NEEDS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> adv); // R3
endmodule

bind pwm_aq_timer pwm_aq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .zero_evt(zero_evt), .cmp_evt(cmp_evt),
  .tb_en(tb_en_q), .freeze(freeze_q), .cnt_wr(cnt_wr),
  .cmp_act_a(cact_q[0]), .cnt(cnt), .pwm_a(pwm_a)
);

// File: tb/tb_pwm_aq_timer.sv
module tb_pwm_aq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b;
  logic [15:0] tb_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pwm_aq_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .tb_count(tb_count)
  );

  // coarse, fine, period, compare A, compare B
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0, 0, 9, 3, 5},
    '{1, 0, 7, 4, 2},
    '{0, 1, 6, 2, 6},
    '{3, 2, 4, 1, 3},
    '{2, 3, 5, 5, 1},
    '{7, 7, 2, 1, 2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 3'(addr);
    wr_data = 16'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int ratio_of(input int c, input int f);
    return (1 << c) * ((f == 0) ? 1 : 2 * f);
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 pwm_a", int'(pwm_a), 0);
    check("R1 pwm_b", int'(pwm_b), 0);
    check("R1 count", int'(tb_count), 0);
    repeat (5) @(negedge clk);
    check("R8 idle after reset", int'(tb_count), 0);

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      int r, per, win, ha, hb, rises, guard;
      logic pa;
      r   = ratio_of(VEC[v][0], VEC[v][1]);
      per = r * (VEC[v][2] + 1);
      win = 2 * per;
      wr(0, 1 << 6);
      wr(4, 16'h00C6);
      wr(1, VEC[v][2]);
      wr(2, VEC[v][3]);
      wr(3, VEC[v][4]);
      wr(5, 0);
      wr(0, VEC[v][0] | (VEC[v][1] << 3) | (1 << 8));
      pa = pwm_a;
      guard = 0;
      while (!(pwm_a && !pa) && guard < 5 * per + 20) begin
        pa = pwm_a;
        @(negedge clk);
        guard++;
      end
      ha = 0; hb = 0; rises = 0;
      pa = pwm_a;
      for (int i = 0; i < win; i++) begin
        if (pwm_a) ha++;
        if (pwm_b) hb++;
        if (i > 0 && pwm_a && !pa) rises++;
        pa = pwm_a;
        @(negedge clk);
      end
      check("R2 R3 one zero event per period", rises, 1);
      check("R4 A high cycles", ha, 2 * r * VEC[v][3]);
      check("R5 B toggle half duty", hb, per);
    end

    // R9: counter write, then R7 freeze
    wr(0, (1 << 6) | (1 << 8));
    wr(5, 16'h1234);
    check("R9 counter load", int'(tb_count), 16'h1234);
    begin
      logic a0, b0;
      a0 = pwm_a; b0 = pwm_b;
      repeat (6) @(negedge clk);
      check("R7 freeze count", int'(tb_count), 16'h1234);
      check("R7 freeze pwm_a", int'(pwm_a), int'(a0));
      check("R7 freeze pwm_b", int'(pwm_b), int'(b0));
    end

    // R8: enable clear holds counter
    wr(0, 0);
    wr(5, 7);
    repeat (6) @(negedge clk);
    check("R8 hold when disabled", int'(tb_count), 7);

    // R10: immediate period write
    wr(1, 9);
    wr(5, 5);
    wr(1, 3);
    wr(0, 1 << 8);
    begin
      bit seen0 = 0, seen6 = 0;
      int mx_after = 0;
      for (int i = 0; i < 12; i++) begin
        if (seen0 && int'(tb_count) > mx_after) mx_after = int'(tb_count);
        if (tb_count == 0) seen0 = 1;
        if (tb_count == 6) seen6 = 1;
        @(negedge clk);
      end
      check("R10 no step past new period", int'(seen6), 0);
      check("R10 wraps to zero", int'(seen0), 1);
      check("R10 max after wrap", mx_after, 3);
    end

    // R11: shadowed period write
    wr(0, 0);
    wr(1, 9);
    wr(5, 5);
    wr(0, 1 << 7);
    wr(1, 3);
    wr(0, (1 << 7) | (1 << 8));
    begin
      bit seen0 = 0;
      int mx_before = 0, mx_after = 0;
      for (int i = 0; i < 20; i++) begin
        if (tb_count == 0) seen0 = 1;
        if (!seen0 && int'(tb_count) > mx_before) mx_before = int'(tb_count);
        if (seen0 && int'(tb_count) > mx_after) mx_after = int'(tb_count);
        @(negedge clk);
      end
      check("R11 old period completes", mx_before, 9);
      check("R11 new period after zero", mx_after, 3);
    end

    // R6: compare of 0 coincides with zero event, compare wins
    wr(0, 0);
    wr(4, 16'h0006);
    wr(2, 0);
    wr(1, 4);
    wr(5, 0);
    wr(0, 1 << 8);
    begin
      int hi = 0;
      for (int i = 0; i < 30; i++) begin
        if (i >= 10 && pwm_a) hi++;
        @(negedge clk);
      end
      check("R6 compare action wins", hi, 0);
    end

    // R5: toggle on zero for B, none for A
    wr(0, 0);
    wr(4, 16'h0030);
    wr(3, 2);
    wr(1, 4);
    wr(0, 1 << 8);
    repeat (3) @(negedge clk);
    begin
      int tb_n = 0, ta_n = 0;
      logic pa, pb;
      pa = pwm_a; pb = pwm_b;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (pwm_a != pa) ta_n++;
        if (pwm_b != pb) tb_n++;
        pa = pwm_a; pb = pwm_b;
      end
      check("R5 toggle on zero", tb_n, 4);
      check("R5 none leaves A", ta_n, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule